// File: doc/BRIEF.md
# Pipelined Two-Array Merge Controller

The block merges two ascending sorted arrays, X and Y, into one ascending output array. All three arrays live in a shared dual-port RAM with a synchronous read. The controller reads only through port A and writes only through port B. It keeps one head register for each input array and compares the two heads. Each cycle it writes the smaller head and fetches the successor of the consumed element. The fetch and the write-back happen on different ports in the same cycle. Returned read data is forwarded straight into the comparison, so one element is merged every clock despite the one-cycle read latency.

A one-cycle `start` pulse launches a merge. The first two cycles only fetch X[0] and then Y[0]. After them, one result is written per cycle until all `LEN_X + LEN_Y` elements are stored. When one array runs out, the rest of the other is copied through unchanged. A single-cycle `done` pulse follows the last write. The array lengths and the three base addresses are parameters. The output region must not overlap either input region.

Top module: `dual_merge`

## Requirements
- R1: After a run, output addresses `BASE_O` to `BASE_O+LEN_X+LEN_Y-1` hold the ascending merge of X and Y. The writes go to consecutive ascending addresses, and each written value is no smaller than the one written before it.
- R2: Writes use port B only and fall only inside the output region. Reads use port A only. In a cycle with both a read and a write, the two addresses differ. Input regions and words past the output region are never written.
- R3: Count the cycle in which `start` is high and accepted as cycle 0. Cycle 0 reads address `BASE_X` (X[0]) and cycle 1 reads `BASE_Y` (Y[0]). Writes occur on every cycle from 2 through `LEN_X+LEN_Y+1` and on no other cycle.
- R4: `done` is high for exactly one cycle, cycle `LEN_X+LEN_Y+2`, which is 12 for the default 5+5 case.
- R5: On equal heads the X element is consumed first. The read issued in that write cycle therefore targets the next X address.
- R6: Each consumed element triggers a read of the next element of its own array, unless that array is exhausted. Each input element is read exactly once (`LEN_X+LEN_Y` reads per run). After exhaustion, the remainder of the other array is copied without comparison.
- R7: A `start` pulse while a merge is in progress is ignored. Read order, written data and `done` timing are unchanged.
- R8: While `rst_n` is low (synchronous, active low), `done`, `rd_en` and `wr_en` are low after the first clock edge. A run started after a reset that interrupted an earlier run completes correctly.
- R9: With no `start`, an idle controller drives `rd_en`, `wr_en` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| done | output | 1 | One-cycle pulse after the final write |
| rd_en | output | 1 | Port A read enable |
| rd_addr | output | ADDR_W | Port A read address |
| rd_data | input | DATA_W | Port A read data, valid the cycle after the read |
| wr_en | output | 1 | Port B write enable |
| wr_addr | output | ADDR_W | Port B write address |
| wr_data | output | DATA_W | Port B write data |

## Verification
The bench goes after the following corner cases, each with a distinct failure signature:
- **Fully disjoint inputs.** One array is wholly smaller than the other, in each direction. A controller that mishandles exhaustion would compare against a stale head, duplicate an element or read past an array's end.
- **Ties.** Equal values inside one array and across both arrays, including all-equal inputs. These catch a comparator that prefers Y or that drops one of two equal heads. The slip shows in the logged read order even where the written values look right.
- **Forwarding of returned data.** Cycle-exact checks on the first read, the first write and the `done` cycle catch a missing or misaligned bypass. Such a design would write a stale head or need extra cycles per element.
- **Interruptions.** A mid-run `start` and a mid-run reset expose a controller that restarts its counters while busy.

// File: rtl/merge_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the two-array merge controller.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package merge_pkg;

    // Sequencer phases: idle, second priming read, compare-and-store, finish pulse.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2,
        ST_FIN   = 2'd3
    } mrg_state_e;

endpackage

// File: rtl/mrg_head.sv
`timescale 1ns/1ps
// Module: mrg_head
// Holds the current head element of one input array and its read index.
// Issues a read on launch (index 0) or when the head is consumed and more
// elements remain. The data returned on the next cycle is forwarded to the
// effective head output at once and kept in the hold register unless it is
// consumed in that same cycle.
// Assumes: the RAM returns read data exactly one cycle after the request;
// launch and take are never high together; LEN >= 1.
module mrg_head #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int LEN    = 5,
    parameter int BASE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              take,
    input  logic [DATA_W-1:0] rd_data,
    output logic              eff_vld,
    output logic [DATA_W-1:0] eff_data,
    output logic              req,
    output logic [ADDR_W-1:0] req_addr
);
    localparam int IDX_W = $clog2(LEN + 1);

    logic [IDX_W-1:0]  idx;
    logic              pend;
    logic              full;
    logic [DATA_W-1:0] hold;
    logic              more;
    logic [ADDR_W-1:0] offset;

    // Whether an unread element remains in this array.
    assign more = (idx < IDX_W'(LEN));
    assign req  = launch | (take & more);

    // Offset of the element being requested this cycle.
    always_comb begin
        offset = launch ? '0 : ADDR_W'(idx);
    end
    assign req_addr = ADDR_W'(BASE) + offset;

    // Effective head: forwarded read data when it arrives this cycle.
    assign eff_vld  = full | pend;
    assign eff_data = pend ? rd_data : hold;

    // Next-index counter for this array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (launch) begin
            idx <= IDX_W'(1);
        end else if (take && more) begin
            idx <= idx + IDX_W'(1);
        end
    end

    // Marks that the read data on the port belongs to this array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            pend <= req;
        end
    end

    // Tracks whether the hold register carries an unconsumed element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (launch || take) begin
            full <= 1'b0;
        end else if (pend) begin
            full <= 1'b1;
        end
    end

    // Captures arriving data that was not consumed on arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (pend && !take) begin
            hold <= rd_data;
        end
    end

endmodule

// File: rtl/mrg_pick.sv
`timescale 1ns/1ps
// Module: mrg_pick
// Chooses which head to emit: the smaller valid head, X on a tie, and the
// sole valid head once the other array is exhausted.
// Assumes: at least one head is valid whenever the choice is used.
module mrg_pick #(
    parameter int DATA_W = 8
) (
    input  logic              x_vld,
    input  logic [DATA_W-1:0] x_data,
    input  logic              y_vld,
    input  logic [DATA_W-1:0] y_data,
    output logic              pick_x,
    output logic              pick_y,
    output logic [DATA_W-1:0] out_data
);
    // Selection with X preferred on equality.
    always_comb begin
        pick_x   = x_vld && (!y_vld || (x_data <= y_data));
        pick_y   = !pick_x && y_vld;
        out_data = pick_x ? x_data : y_data;
    end

endmodule

// File: rtl/mrg_seq.sv
`timescale 1ns/1ps
// Module: mrg_seq
// Phase sequencer and output counter. It launches the X fetch when idle and
// started, launches the Y fetch on the next cycle, then writes TOTAL results
// on consecutive cycles and raises done for one cycle.
// Assumes: TOTAL >= 2; start is ignored outside the idle phase.
module mrg_seq
    import merge_pkg::*;
#(
    parameter int TOTAL = 10,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             launch_x,
    output logic             launch_y,
    output logic             write,
    output logic [CNT_W-1:0] wcnt,
    output logic             done
);
    mrg_state_e state;
    logic       last;

    // Phase decodes.
    assign launch_x = (state == ST_IDLE) && start;
    assign launch_y = (state == ST_PRIME);
    assign write    = (state == ST_RUN);
    assign done     = (state == ST_FIN);
    assign last     = write && (wcnt == CNT_W'(TOTAL - 1));

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (start) state <= ST_PRIME;
                ST_PRIME: state <= ST_RUN;
                ST_RUN:   if (last) state <= ST_FIN;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Output index counter, cleared at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (launch_x) begin
            wcnt <= '0;
        end else if (write) begin
            wcnt <= wcnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dual_merge.sv
`timescale 1ns/1ps
// Module: dual_merge (top)
// Merges two ascending arrays held in a dual-port RAM into an ascending
// output region at one element per clock after two priming reads.
// Port A is read-only, port B is write-only.
// Assumes: the RAM read data is registered (one-cycle latency); the inputs
// are sorted ascending; the output region overlaps neither input region;
// LEN_X, LEN_Y >= 1.
module dual_merge #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int LEN_X  = 5,
    parameter int LEN_Y  = 5,
    parameter int BASE_X = 0,
    parameter int BASE_Y = 8,
    parameter int BASE_O = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int TOTAL = LEN_X + LEN_Y;
    localparam int CNT_W = $clog2(TOTAL + 1);

    logic              launch_x, launch_y, write;
    logic [CNT_W-1:0]  wcnt;
    logic              x_vld, y_vld, pick_x, pick_y;
    logic [DATA_W-1:0] x_data, y_data, sel_data;
    logic              req_x, req_y;
    logic [ADDR_W-1:0] addr_x, addr_y;

    mrg_seq #(.TOTAL(TOTAL), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .launch_x (launch_x),
        .launch_y (launch_y),
        .write    (write),
        .wcnt     (wcnt),
        .done     (done)
    );

    mrg_head #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN(LEN_X), .BASE(BASE_X)) u_head_x (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch_x),
        .take     (write & pick_x),
        .rd_data  (rd_data),
        .eff_vld  (x_vld),
        .eff_data (x_data),
        .req      (req_x),
        .req_addr (addr_x)
    );

    mrg_head #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN(LEN_Y), .BASE(BASE_Y)) u_head_y (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch_y),
        .take     (write & pick_y),
        .rd_data  (rd_data),
        .eff_vld  (y_vld),
        .eff_data (y_data),
        .req      (req_y),
        .req_addr (addr_y)
    );

    mrg_pick #(.DATA_W(DATA_W)) u_pick (
        .x_vld    (x_vld),
        .x_data   (x_data),
        .y_vld    (y_vld),
        .y_data   (y_data),
        .pick_x   (pick_x),
        .pick_y   (pick_y),
        .out_data (sel_data)
    );

    // Port A: at most one head requests per cycle.
    assign rd_en   = req_x | req_y;
    assign rd_addr = req_x ? addr_x : addr_y;

    // Port B: one result per run-phase cycle.
    assign wr_en   = write;
    assign wr_addr = ADDR_W'(BASE_O) + ADDR_W'(wcnt);
    assign wr_data = sel_data;

endmodule

// File: rtl/dual_merge_chk.sv
`timescale 1ns/1ps
// Module: dual_merge_chk
// Port-level protocol checker for dual_merge, attached with bind.
// Assumes: inputs presented to the merge are sorted ascending.
module dual_merge_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int LEN_X  = 5,
    parameter int LEN_Y  = 5,
    parameter int BASE_O = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);
    localparam int TOTAL = LEN_X + LEN_Y;

    // R2: simultaneous read and write target different words.
    p_split_ports_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> (rd_addr != wr_addr));

    // R2: writes land only in the output region.
    p_out_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((int'(wr_addr) >= BASE_O) && (int'(wr_addr) < BASE_O + TOTAL)));

    // R1: back-to-back writes step the address by one.
    p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

    // R1: back-to-back written values never decrease.
    p_ascending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_data >= $past(wr_data)));

    // R4: done lasts one cycle.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done directly follows a write.
    p_done_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en));

    // R3: a write burst ends either in another write or in done.
    p_burst_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_en || done));

endmodule

bind dual_merge dual_merge_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .LEN_X  (LEN_X),
    .LEN_Y  (LEN_Y),
    .BASE_O (BASE_O)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
);

// File: tb/dual_merge_tb.sv
`timescale 1ns/1ps
module dual_merge_tb;
    localparam int DW = 8, AW = 6, LX = 5, LY = 5, BX = 0, BY = 8, BO = 16;
    localparam int TOT = LX + LY, NV = 6;

    // Vector table: element i of an array is bits [8*i +: 8].
    localparam logic [39:0] VX [NV] = '{
        {8'd9,  8'd7,  8'd5,  8'd3,  8'd1},
        {8'd5,  8'd4,  8'd3,  8'd2,  8'd1},
        {8'd24, 8'd23, 8'd22, 8'd21, 8'd20},
        {8'd9,  8'd4,  8'd4,  8'd2,  8'd2},
        {8'd255,8'd0,  8'd0,  8'd0,  8'd0},
        {8'd10, 8'd10, 8'd10, 8'd10, 8'd10}
    };
    localparam logic [39:0] VY [NV] = '{
        {8'd10, 8'd8,  8'd6,  8'd4,  8'd2},
        {8'd10, 8'd9,  8'd8,  8'd7,  8'd6},
        {8'd4,  8'd3,  8'd2,  8'd1,  8'd0},
        {8'd9,  8'd8,  8'd4,  8'd4,  8'd2},
        {8'd255,8'd255,8'd255,8'd0,  8'd0},
        {8'd10, 8'd10, 8'd10, 8'd10, 8'd10}
    };

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic          done, rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] wr_data, rd_q;
    logic [DW-1:0] mem [64];
    int            n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    dual_merge #(.DATA_W(DW), .ADDR_W(AW), .LEN_X(LX), .LEN_Y(LY),
                 .BASE_X(BX), .BASE_Y(BY), .BASE_O(BO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_q),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Dual-port RAM model with registered read data.
    always @(posedge clk) begin
        if (rd_en) rd_q <= mem[rd_addr];
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Runs vector v; mid adds an extra start pulse in cycle 5 (R7).
    task automatic run_vec(input int v, input bit mid);
        int eo [TOT];
        int er [TOT];
        int ner = 0, ix = 0, iy = 0;
        int rl_a [40];
        int rl_c [40];
        int nrd = 0, first_wr = -1, nwr = 0, done_k = -1, ndone = 0, bad = 0;
        int rd_mis = -1;
        bit out_ok = 1'b1, in_ok = 1'b1;
        for (int a = 0; a < 64; a++) mem[a] = 8'hEE;
        for (int i = 0; i < LX; i++) mem[BX + i] = VX[v][8*i +: 8];
        for (int i = 0; i < LY; i++) mem[BY + i] = VY[v][8*i +: 8];
        // Reference merge and expected read order, X first on ties.
        er[ner++] = BX;
        er[ner++] = BY;
        for (int o = 0; o < TOT; o++) begin
            if (ix < LX && (iy >= LY || VX[v][8*ix +: 8] <= VY[v][8*iy +: 8])) begin
                eo[o] = int'(VX[v][8*ix +: 8]);
                ix++;
                if (ix < LX) er[ner++] = BX + ix;
            end else begin
                eo[o] = int'(VY[v][8*iy +: 8]);
                iy++;
                if (iy < LY) er[ner++] = BY + iy;
            end
        end
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            start = (k == 0) || (mid && k == 5);
            #1;
            if (rd_en && nrd < 40) begin
                rl_a[nrd] = int'(rd_addr);
                rl_c[nrd] = k;
                nrd++;
            end
            if (wr_en) begin
                if (first_wr < 0) first_wr = k;
                nwr++;
                if (int'(wr_addr) < BO || int'(wr_addr) >= BO + TOT) bad++;
                if (rd_en && rd_addr == wr_addr) bad++;
            end
            if (done) begin
                if (done_k < 0) done_k = k;
                ndone++;
            end
            if (done_k >= 0 && k == done_k + 1) break;
        end
        start = 1'b0;
        @(negedge clk);
        for (int o = 0; o < TOT; o++) if (int'(mem[BO + o]) != eo[o]) out_ok = 1'b0;
        for (int i = 0; i < LX; i++) if (mem[BX + i] != VX[v][8*i +: 8]) in_ok = 1'b0;
        for (int i = 0; i < LY; i++) if (mem[BY + i] != VY[v][8*i +: 8]) in_ok = 1'b0;
        for (int r = 0; r < ner && r < nrd; r++) if (rd_mis < 0 && rl_a[r] != er[r]) rd_mis = r;
        chk(out_ok, $sformatf("R1 merged output v%0d", v), int'(out_ok), 1);
        chk(bad == 0 && in_ok && mem[BO + TOT] == 8'hEE,
            $sformatf("R2 port/region use v%0d", v), bad, 0);
        chk(nrd >= 2 && rl_c[0] == 0 && rl_a[0] == BX && rl_c[1] == 1 && rl_a[1] == BY,
            $sformatf("R3 priming reads v%0d", v), (nrd >= 2) ? rl_a[1] : -1, BY);
        chk(first_wr == 2 && nwr == TOT, $sformatf("R3 write window v%0d", v),
            first_wr * 100 + nwr, 2 * 100 + TOT);
        chk(done_k == TOT + 2 && ndone == 1, $sformatf("R4 done cycle v%0d", v), done_k, TOT + 2);
        chk(nrd == ner, $sformatf("R6 read count v%0d", v), nrd, ner);
        chk(rd_mis < 0, $sformatf("R5 read order v%0d", v),
            (rd_mis < 0) ? 0 : rl_a[rd_mis], (rd_mis < 0) ? 0 : er[rd_mis]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!done && !rd_en && !wr_en, "R8 reset outputs", int'({done, rd_en, wr_en}), 0);
        rst_n = 1'b1;
        // R9: idle without start keeps ports quiet.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1;
            chk(!done && !rd_en && !wr_en, "R9 idle quiet", int'({done, rd_en, wr_en}), 0);
        end
        // Main vector walk.
        for (int v = 0; v < NV; v++) run_vec(v, 1'b0);
        // R7: mid-run start on the base and all-tie vectors.
        run_vec(0, 1'b1);
        run_vec(5, 1'b1);
        // R8: reset in the middle of a run, then a clean run.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!done && !rd_en && !wr_en, "R8 mid-run reset", int'({done, rd_en, wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!done && !rd_en && !wr_en, "R9 idle after reset", int'({done, rd_en, wr_en}), 0);
        run_vec(3, 1'b0);
        summary();
        $finish;
    end
endmodule